// File: doc/BRIEF.md
# Bus Access Dead-Time Throttle

This block sits between a bus master's request logic and the master's bus interface and caps how much bus bandwidth the master uses. Each time the bus signals that a transfer has finished, a down-counter in the bus clock domain is loaded with a programmable idle-gap length. The next access is held off until that counter has drained to zero.

The master presents a request and the block forwards it to the bus only while the gap window is open. The bus's own ready is passed back to the master under the same gate. Throttling can be switched off, and a gap of zero adds nothing. A request raised during a gap is kept waiting, not lost, and goes out on the first open cycle.

Top module: `bus_gap_throttle`

## Requirements
- R1: After reset the gap counter is zero, so `busReq` follows `mstReq` and `mstRdy` follows `busRdy` with no wait.
- R2: While `throttleEn` is 0 (and was 0 on the previous cycle), a completed transfer adds no blocked cycles.
- R3: With `throttleEn` set and `gapCycles` equal to 0, a completed transfer adds no blocked cycles.
- R4: With `throttleEn` set and `gapCycles` equal to N (1..255), the N cycles that follow a cycle with `busDone` high have `busReq` and `mstRdy` low.
- R5: The gap length is an 8-bit value, so a setting of 255 blocks exactly 255 cycles.
- R6: A request held high through a gap is not dropped: `busReq` is high on the first open cycle after the count reaches zero.
- R7: A new `gapCycles` value written during a countdown does not change that countdown; it takes effect at the next `busDone`.
- R8: Clearing `throttleEn` during a countdown leaves the current cycle blocked and opens the gate on the next cycle.
- R9: A `busDone` that arrives during a countdown reloads the counter with `gapCycles` and restarts the gap.
- R10: `busReq` is high only when `mstReq` is high, and `mstRdy` is high only when `busRdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the counter also runs on this clock |
| rstN | input | 1 | Active-low synchronous reset |
| throttleEn | input | 1 | 1 turns on gap insertion |
| gapCycles | input | 8 | Number of idle cycles to insert after each transfer |
| mstReq | input | 1 | Request from the master's request logic |
| busRdy | input | 1 | Ready from the bus interface |
| busDone | input | 1 | One-cycle pulse: a bus transfer has completed |
| busReq | output | 1 | Gated request toward the bus interface |
| mstRdy | output | 1 | Gated ready back to the master |

## Verification
A table of gap settings is walked, and each setting is paired with the enable bit. Zero gaps and the disabled case show that no latency is added. The values 1, 2 and 7 show that the blocked length tracks the setting exactly and is not off by one. A gap of 255 shows that the full 8-bit range is counted. Directed runs then change the gap value, drop the enable, and fire a second completion, each partway through a countdown. These runs separate a counter that reloads only on completion from one that follows the live inputs. Finally, the request and ready inputs are lowered one at a time to show that the gate never creates a handshake on its own.

// File: rtl/gap_throttle_pkg.sv
package gap_throttle_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } gapStrobes_t;
endpackage

// File: rtl/gap_ctrl.sv
module gap_ctrl
  import gap_throttle_pkg::*;
(
  input  logic        throttleEn,
  input  logic        busDone,
  input  logic        isZero,
  output gapStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (busDone) begin
      // A completion starts a new gap, or flushes the counter when disabled.
      if (throttleEn) strobes.load = 1'b1;
      else            strobes.clear = 1'b1;
    end else if (!isZero) begin
      if (throttleEn) strobes.dec = 1'b1;
      else            strobes.clear = 1'b1;
    end
  end
endmodule

// File: rtl/gap_datapath.sv
module gap_datapath
  import gap_throttle_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  gapStrobes_t      strobes,
  input  logic [CNT_W-1:0] gapCycles,
  output logic [CNT_W-1:0] gapCount,
  output logic             isZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCount <= '0;
    end else if (strobes.load) begin
      gapCount <= gapCycles;
    end else if (strobes.clear) begin
      gapCount <= '0;
    end else if (strobes.dec) begin
      gapCount <= gapCount - ONE;
    end
  end

  assign isZero = (gapCount == '0);
endmodule

// File: rtl/bus_gap_throttle.sv
module bus_gap_throttle
  import gap_throttle_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             throttleEn,
  input  logic [CNT_W-1:0] gapCycles,
  input  logic             mstReq,
  input  logic             busRdy,
  input  logic             busDone,
  output logic             busReq,
  output logic             mstRdy
);
  gapStrobes_t      strobes;
  logic             isZero;
  logic [CNT_W-1:0] gapCount;

  gap_ctrl u_ctrl (
    .throttleEn(throttleEn),
    .busDone   (busDone),
    .isZero    (isZero),
    .strobes   (strobes)
  );

  gap_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .gapCycles(gapCycles),
    .gapCount (gapCount),
    .isZero   (isZero)
  );

  // The gate opens only on the registered count, so a dropped enable
  // releases one cycle later.
  assign busReq = mstReq & isZero;
  assign mstRdy = busRdy & isZero;
endmodule

// File: rtl/gap_throttle_checker.sv
module gap_throttle_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             throttleEn,
  input logic [CNT_W-1:0] gapCycles,
  input logic             mstReq,
  input logic             busRdy,
  input logic             busDone,
  input logic             busReq,
  input logic             mstRdy,
  input logic [CNT_W-1:0] gapCount
);
  a_r4_gap_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (busDone && throttleEn && gapCycles != '0) |=> (!busReq && !mstRdy));

  a_r2_disabled_pass: assert property (@(posedge clk) disable iff (!rstN)
    !$past(throttleEn) |-> (busReq == mstReq && mstRdy == busRdy));

  a_r7_countdown_step: assert property (@(posedge clk) disable iff (!rstN)
    (gapCount != '0 && throttleEn && !busDone) |=> gapCount == $past(gapCount) - CNT_W'(1));

  a_r8_enable_release: assert property (@(posedge clk) disable iff (!rstN)
    (gapCount != '0 && !throttleEn && !busDone) |=> (busReq == mstReq && mstRdy == busRdy));

  a_r9_reload: assert property (@(posedge clk) disable iff (!rstN)
    (busDone && throttleEn) |=> gapCount == $past(gapCycles));

  a_r10_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> mstReq);

  a_r10_rdy_gated: assert property (@(posedge clk) disable iff (!rstN)
    mstRdy |-> busRdy);
endmodule

bind bus_gap_throttle gap_throttle_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .throttleEn(throttleEn),
  .gapCycles (gapCycles),
  .mstReq    (mstReq),
  .busRdy    (busRdy),
  .busDone   (busDone),
  .busReq    (busReq),
  .mstRdy    (mstRdy),
  .gapCount  (gapCount)
);

// File: tb/sim_bus_gap_throttle.sv
`timescale 1ns/1ps
module sim_bus_gap_throttle;
  logic       clk = 1'b0;
  logic       rstN;
  logic       throttleEn;
  logic [7:0] gapCycles;
  logic       mstReq;
  logic       busRdy;
  logic       busDone;
  logic       busReq;
  logic       mstRdy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_gap_throttle u0 (
    .clk(clk), .rstN(rstN), .throttleEn(throttleEn), .gapCycles(gapCycles),
    .mstReq(mstReq), .busRdy(busRdy), .busDone(busDone),
    .busReq(busReq), .mstRdy(mstRdy)
  );

  // {enable, gap, expected blocked cycles}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'd0,   8'd0},
    {1'b0, 8'd5,   8'd0},
    {1'b1, 8'd1,   8'd1},
    {1'b1, 8'd7,   8'd7},
    {1'b1, 8'd255, 8'd255},
    {1'b0, 8'd255, 8'd0},
    {1'b1, 8'd2,   8'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse busDone for one cycle, then count blocked cycles. At blocked index
  // changeAt the enable and gap are rewritten, and busDone optionally refires.
  task automatic pulseAndMeasure(input logic en, input logic [7:0] gap,
                                 input int changeAt, input logic newEn,
                                 input logic [7:0] newGap, input bit redo,
                                 output int blocked, output logic reqAtOpen);
    @(negedge clk);
    throttleEn = en;
    gapCycles  = gap;
    busDone    = 1'b1;
    @(negedge clk);
    busDone = 1'b0;
    blocked = 0;
    #1;
    while (!mstRdy && blocked < 400) begin
      if (blocked == changeAt) begin
        throttleEn = newEn;
        gapCycles  = newGap;
        busDone    = redo;
      end
      blocked++;
      @(negedge clk);
      busDone = 1'b0;
      #1;
    end
    reqAtOpen = busReq;
  endtask

  initial begin
    int blk;
    logic rq;
    rstN = 1'b0; throttleEn = 1'b0; gapCycles = 8'd0;
    mstReq = 1'b1; busRdy = 1'b1; busDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 busReq after reset", int'(busReq), 1);
    check("R1 mstRdy after reset", int'(mstRdy), 1);

    for (int i = 0; i < NV; i++) begin
      pulseAndMeasure(VEC[i][16], VEC[i][15:8], -1, 1'b0, 8'd0, 1'b0, blk, rq);
      if (!VEC[i][16])            check("R2 disabled gap", blk, int'(VEC[i][7:0]));
      else if (VEC[i][15:8] == 0) check("R3 zero gap", blk, 0);
      else if (VEC[i][15:8] == 255) check("R5 full-range gap", blk, 255);
      else                        check("R4 gap length", blk, int'(VEC[i][7:0]));
      check("R6 held request at open", int'(rq), 1);
    end

    // R7: gap value changed mid-countdown, then used at the next reload
    pulseAndMeasure(1'b1, 8'd10, 3, 1'b1, 8'd2, 1'b0, blk, rq);
    check("R7 countdown unchanged", blk, 10);
    pulseAndMeasure(1'b1, 8'd2, -1, 1'b0, 8'd0, 1'b0, blk, rq);
    check("R7 new value at reload", blk, 2);

    // R8: enable dropped at the fifth blocked cycle
    pulseAndMeasure(1'b1, 8'd20, 4, 1'b0, 8'd20, 1'b0, blk, rq);
    check("R8 release after enable clear", blk, 5);

    // R9: second completion at blocked index 3 restarts a 6-cycle gap
    pulseAndMeasure(1'b1, 8'd6, 3, 1'b1, 8'd6, 1'b1, blk, rq);
    check("R9 reload during countdown", blk, 10);

    // R10: gating of request and ready with the gate open
    @(negedge clk);
    throttleEn = 1'b0; mstReq = 1'b0; busRdy = 1'b0;
    #1;
    check("R10 busReq low with mstReq low", int'(busReq), 0);
    check("R10 mstRdy low with busRdy low", int'(mstRdy), 0);
    @(negedge clk);
    mstReq = 1'b1;
    #1;
    check("R10 busReq follows mstReq", int'(busReq), 1);
    check("R10 mstRdy stays low", int'(mstRdy), 0);

    // R4: gate closed blocks even a present request and ready
    busRdy = 1'b1;
    @(negedge clk);
    throttleEn = 1'b1; gapCycles = 8'd3; busDone = 1'b1;
    @(negedge clk);
    busDone = 1'b0;
    #1;
    check("R4 busReq blocked in gap", int'(busReq), 0);
    check("R4 mstRdy blocked in gap", int'(mstRdy), 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule